// File: doc/BRIEF.md
# Serial Port Register Front End

This block is the software-visible side of a byte-oriented serial port. A processor reaches it over a simple 32-bit bus with one-cycle read and write strobes and a word address. Writing the transmit data word hands its low byte to a transmitter as a single-cycle strobe. Bytes coming from a receiver are offered on a valid/ready interface and are queued in a 16-entry receive FIFO. Software drains the FIFO through a combined status/data word. That word exists twice: one copy only looks at the oldest byte, and the other also removes it.

The block keeps raw interrupt status, an interrupt mask and a masked view, and drives one level-sensitive interrupt line. The receive-pending interrupt follows the FIFO level directly. The transmit interrupts are latched and are cleared by writes to an acknowledge word. The first acknowledge after a transmit write cannot clear the transmit-done bit. Bit-level framing, baud timing, parity and DMA belong to other blocks. The remaining words in the window are plain 32-bit storage.

Top module: `sio_reg_block`

## Requirements
- R1: After a synchronous reset the receive control word (word 2, byte offset 0x08) reads 0x0001_0000. The FIFO is empty, the raw interrupt word reads 0, and rx_ready, irq and tx_valid are low.
- R2: A write to word 7 (0x1C) makes tx_valid high for exactly the next cycle, with tx_data equal to the low 8 bits written. The same write sets raw interrupt bits 0 and 1 and arms an internal pending-transmit flag.
- R3: rx_ready is high only when bit 3 of the receive control word is 1 and the FIFO is not full. A byte is stored only in a cycle where rx_valid and rx_ready are both high.
- R4: The FIFO holds 16 bytes and returns them in arrival order across pointer wrap-around. At 16 entries rx_ready is low and an offered byte is not stored.
- R5: A status/data read returns the oldest byte in bits 7:0 and data-available in bit 16 (1 when the FIFO is non-empty). Bits 22 and 24 always read 1. All other bits read 0.
- R6: A read of word 8 (0x20) removes the oldest byte when the FIFO is non-empty. A read of word 9 (0x24) returns the same word and leaves the FIFO unchanged.
- R7: A read of word 8 on an empty FIFO returns bit 16 clear and leaves the FIFO empty, with no underflow.
- R8: When a byte is stored and a word-8 read pops in the same cycle, the entry count is unchanged, the read returns the previous head, and the new byte is queued at the tail.
- R9: Raw interrupt bit 3 always equals FIFO non-empty, and an acknowledge write cannot clear it.
- R10: A write to word 12 (0x30) clears every latched raw bit written as 1. If pending-transmit is set, bit 0 of the written value is first treated as 0, and the flag is cleared.
- R11: Word 14 (0x38) reads raw AND mask, where the mask is word 11 (0x2C). irq is high exactly when that value is non-zero.
- R12: Read latency is one cycle. Words 0 to 14, other than 8, 9, 13 and 14, store all 32 written bits and read them back. Writes to 8, 9, 13 and 14 do not change what those words read. Word 15 reads 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Word address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| tx_data | output | 8 | Byte toward the transmitter |
| tx_valid | output | 1 | One-cycle transmit strobe |
| rx_data | input | 8 | Incoming byte |
| rx_valid | input | 1 | Incoming byte valid |
| rx_ready | output | 1 | FIFO can accept a byte |
| irq | output | 1 | Level interrupt |

## Verification
The hardest situation to reach is a pop and a push landing on the same clock edge while the read pointer has already wrapped. At that point the count must hold and the order must survive. The stimulus first fills the FIFO to the point where it refuses bytes, then drains it completely and pops it once more while empty. It then refills past the wrap point and drives rx_valid and a word-8 read together for several cycles, comparing each result against a queue model kept in the bench. The interrupt mask is swept over all sixteen low-bit values while the raw word holds a known mix of latched and level bits.

// File: rtl/sio_pkg.sv
package sio_pkg;
  // word indices inside the register window
  localparam int unsigned W_RX_CTRL   = 2;
  localparam int unsigned W_DOUT      = 7;
  localparam int unsigned W_STAT_POP  = 8;
  localparam int unsigned W_STAT_PEEK = 9;
  localparam int unsigned W_MASK      = 11;
  localparam int unsigned W_ACK       = 12;
  localparam int unsigned W_RAW       = 13;
  localparam int unsigned W_MASKED    = 14;
  localparam int unsigned W_LIMIT     = 15;

  // bit positions
  localparam int unsigned B_AVAIL   = 16;
  localparam int unsigned B_TX_IDLE = 22;
  localparam int unsigned B_TX_RDY  = 24;
  localparam int unsigned B_RX_EN   = 3;
  localparam int unsigned B_IRQ_RX  = 3;

  localparam logic [31:0] RX_CTRL_INIT = 32'h0001_0000;

  // words whose read value is computed rather than stored
  function automatic bit is_computed(int unsigned w);
    return (w == W_STAT_POP) || (w == W_STAT_PEEK) ||
           (w == W_RAW) || (w == W_MASKED) || (w >= W_LIMIT);
  endfunction
endpackage

// File: rtl/sio_rx_fifo.sv
module sio_rx_fifo #(
  parameter int DEPTH = 16,   // power of two
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             push,
  input  logic             pop,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] head,
  output logic             empty,
  output logic             full
);
  localparam int PW = $clog2(DEPTH);
  localparam logic [PW:0] FULL_CNT = (PW+1)'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    wr_ptr, rd_ptr;
  logic [PW:0]      count;
  logic             do_push, do_pop;

  assign do_push = push && !full;
  assign do_pop  = pop && !empty;

  // storage: no reset so it maps onto RAM
  always_ff @(posedge clk) begin
    if (do_push) mem[wr_ptr] <= din;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (do_push) wr_ptr <= wr_ptr + 1'b1;
      if (do_pop)  rd_ptr <= rd_ptr + 1'b1;
      case ({do_push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign head  = mem[rd_ptr];
  assign empty = (count == '0);
  assign full  = (count == FULL_CNT);

  // R4: occupancy never exceeds the depth
  p_no_overflow_r4: assert property (@(posedge clk) disable iff (rst)
    count <= FULL_CNT);
  // R7: popping an empty queue leaves it empty
  p_no_underflow_r7: assert property (@(posedge clk) disable iff (rst)
    (pop && !push && empty) |=> empty);
  // R8: simultaneous push and pop keep the count
  p_push_pop_r8: assert property (@(posedge clk) disable iff (rst)
    (push && pop && !empty && !full) |=> $stable(count));
endmodule

// File: rtl/sio_irq_ctl.sv
module sio_irq_ctl #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_wr,
  input  logic              ack_wr,
  input  logic [1:0]        ack_bits,
  input  logic              rx_avail,
  input  logic [DATA_W-1:0] mask,
  output logic [DATA_W-1:0] raw,
  output logic [DATA_W-1:0] masked,
  output logic              irq
);
  import sio_pkg::*;

  logic [1:0] lat_q;
  logic       pend_q;
  logic [1:0] clr;

  always_comb begin
    clr = ack_bits;
    if (pend_q) clr[0] = 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lat_q  <= '0;
      pend_q <= 1'b0;
    end else if (tx_wr) begin
      lat_q  <= 2'b11;
      pend_q <= 1'b1;
    end else if (ack_wr) begin
      lat_q  <= lat_q & ~clr;
      pend_q <= 1'b0;
    end
  end

  always_comb begin
    raw           = '0;
    raw[1:0]      = lat_q;
    raw[B_IRQ_RX] = rx_avail;
  end

  assign masked = raw & mask;
  assign irq    = |masked;

  // R10: the acknowledge right after a transmit keeps bit 0
  p_ack_guard_r10: assert property (@(posedge clk) disable iff (rst)
    (ack_wr && !tx_wr && pend_q) |=> (lat_q[0] == $past(lat_q[0])));
  // R11: no interrupt without an enabled mask bit
  p_irq_masked_r11: assert property (@(posedge clk) disable iff (rst)
    irq |-> (mask != '0));
endmodule

// File: rtl/sio_reg_block.sv
module sio_reg_block #(
  parameter int ADDR_W     = 4,
  parameter int DATA_W     = 32,
  parameter int BYTE_W     = 8,
  parameter int FIFO_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [BYTE_W-1:0] tx_data,
  output logic              tx_valid,
  input  logic [BYTE_W-1:0] rx_data,
  input  logic              rx_valid,
  output logic              rx_ready,
  output logic              irq
);
  import sio_pkg::*;

  localparam int NWORDS = 2 ** ADDR_W;

  logic [DATA_W-1:0] store_w [NWORDS];
  logic [DATA_W-1:0] raw, masked, status, rd_word;
  logic [BYTE_W-1:0] head;
  logic fifo_empty, fifo_full, push, pop, tx_wr, ack_wr;

  // decode
  assign tx_wr  = bus_wr && (bus_addr == ADDR_W'(W_DOUT));
  assign ack_wr = bus_wr && (bus_addr == ADDR_W'(W_ACK));
  assign pop    = bus_rd && (bus_addr == ADDR_W'(W_STAT_POP));
  assign push   = rx_valid && rx_ready;
  assign rx_ready = store_w[W_RX_CTRL][B_RX_EN] && !fifo_full;

  // plain storage words; computed and out-of-window words have no flops
  for (genvar g = 0; g < NWORDS; g++) begin : g_word
    if (is_computed(g)) begin : g_none
      assign store_w[g] = '0;
    end else begin : g_store
      localparam logic [DATA_W-1:0] INIT =
        (g == W_RX_CTRL) ? DATA_W'(RX_CTRL_INIT) : '0;
      logic [DATA_W-1:0] word_q;
      always_ff @(posedge clk) begin
        if (rst)                                      word_q <= INIT;
        else if (bus_wr && bus_addr == ADDR_W'(g))    word_q <= bus_wdata;
      end
      assign store_w[g] = word_q;
    end
  end

  sio_rx_fifo #(.DEPTH(FIFO_DEPTH), .WIDTH(BYTE_W)) u_fifo (
    .clk(clk), .rst(rst), .push(push), .pop(pop), .din(rx_data),
    .head(head), .empty(fifo_empty), .full(fifo_full)
  );

  sio_irq_ctl #(.DATA_W(DATA_W)) u_irq (
    .clk(clk), .rst(rst), .tx_wr(tx_wr), .ack_wr(ack_wr),
    .ack_bits(bus_wdata[1:0]), .rx_avail(!fifo_empty),
    .mask(store_w[W_MASK]), .raw(raw), .masked(masked), .irq(irq)
  );

  always_comb begin
    status              = '0;
    status[BYTE_W-1:0]  = head;
    status[B_AVAIL]     = !fifo_empty;
    status[B_TX_IDLE]   = 1'b1;
    status[B_TX_RDY]    = 1'b1;
  end

  always_comb begin
    case (bus_addr)
      ADDR_W'(W_STAT_POP), ADDR_W'(W_STAT_PEEK): rd_word = status;
      ADDR_W'(W_RAW):                            rd_word = raw;
      ADDR_W'(W_MASKED):                         rd_word = masked;
      default:                                   rd_word = store_w[bus_addr];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
      tx_valid  <= 1'b0;
      tx_data   <= '0;
    end else begin
      if (bus_rd) bus_rdata <= rd_word;
      tx_valid <= tx_wr;
      if (tx_wr) tx_data <= bus_wdata[BYTE_W-1:0];
    end
  end

  // R2: a transmit strobe coincides with both transmit bits latched
  p_tx_raw_r2: assert property (@(posedge clk) disable iff (rst)
    tx_valid |-> (raw[1:0] == 2'b11));
  // R4: the queue only becomes non-empty through an accepted byte
  p_fill_src_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(!fifo_empty) |-> $past(push));
  // R3: nothing is accepted while the receiver is disabled
  p_rx_gate_r3: assert property (@(posedge clk) disable iff (rst)
    !store_w[W_RX_CTRL][B_RX_EN] |-> !rx_ready);
endmodule

// File: tb/test_sio_reg_block.sv
module test_sio_reg_block;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [3:0]  bus_addr = '0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  tx_data, rx_data = '0;
  logic        tx_valid, rx_valid = 1'b0, rx_ready, irq;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] q[$];
  logic [31:0] rv;

  localparam logic [31:0] STAT_BASE = 32'h0140_0000;

  always #2 clk = ~clk;

  sio_reg_block i_sio_reg_block (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .tx_data(tx_data), .tx_valid(tx_valid), .rx_data(rx_data),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .irq(irq)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // every task starts and ends just after a falling edge
  task automatic do_reset();
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    q.delete();
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic push_byte(input logic [7:0] b);
    rx_data = b; rx_valid = 1'b1;
    if (rx_ready) q.push_back(b);
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  function automatic logic [31:0] stat_exp();
    return (q.size() != 0) ? (STAT_BASE | 32'h0001_0000 | {24'h0, q[0]}) : STAT_BASE;
  endfunction

  initial begin
    #(4 * 150000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
    end
    $finish;
  end

  initial begin
    do_reset();
    // R1 reset state
    chk("R1 rx_ready", {31'h0, rx_ready}, 32'h0);
    chk("R1 irq", {31'h0, irq}, 32'h0);
    chk("R1 tx_valid", {31'h0, tx_valid}, 32'h0);
    rd(4'd2, rv);  chk("R1 rx ctrl", rv, 32'h0001_0000);
    rd(4'd13, rv); chk("R1 raw", rv, 32'h0);
    rd(4'd9, rv);  chk("R1 R5 status empty", rv & 32'hFFFF_FF00, STAT_BASE);

    // R12 storage sweep
    for (int w = 0; w < 16; w++)
      if (!(w inside {8, 9, 13, 14})) wr(w[3:0], 32'h5A00_0000 ^ (w * 32'h0103_0507));
    for (int w = 0; w < 16; w++)
      if (!(w inside {8, 9, 13, 14})) begin
        rd(w[3:0], rv);
        chk("R12 storage", rv, (w == 15) ? 32'h0 : (32'h5A00_0000 ^ (w * 32'h0103_0507)));
      end

    // R12 computed words ignore writes
    do_reset();
    wr(4'd8, 32'hFFFF_FFFF); wr(4'd9, 32'hFFFF_FFFF);
    wr(4'd13, 32'hFFFF_FFFF); wr(4'd14, 32'hFFFF_FFFF);
    rd(4'd13, rv); chk("R12 raw write ignored", rv, 32'h0);
    rd(4'd14, rv); chk("R12 masked write ignored", rv, 32'h0);
    rd(4'd9, rv);  chk("R12 status write ignored", rv & 32'hFFFF_FF00, STAT_BASE);
    chk("R12 irq", {31'h0, irq}, 32'h0);

    // R2 transmit strobe
    wr(4'd7, 32'h89AB_CD5E);
    chk("R2 tx_valid high", {31'h0, tx_valid}, 32'h1);
    chk("R2 tx_data", {24'h0, tx_data}, 32'h5E);
    @(negedge clk);
    chk("R2 tx_valid one cycle", {31'h0, tx_valid}, 32'h0);
    rd(4'd13, rv); chk("R2 raw bits", rv, 32'h3);

    // R10 acknowledge guard
    wr(4'd12, 32'hF);
    rd(4'd13, rv); chk("R10 first ack keeps bit0", rv, 32'h1);
    wr(4'd12, 32'h1);
    rd(4'd13, rv); chk("R10 second ack clears bit0", rv, 32'h0);
    wr(4'd7, 32'h11);
    wr(4'd12, 32'h2);
    rd(4'd13, rv); chk("R10 ack bit1 only", rv, 32'h1);
    wr(4'd12, 32'h1);
    rd(4'd13, rv); chk("R10 flag cleared by first ack", rv, 32'h0);

    // R3 receiver disabled
    push_byte(8'hC7);
    rd(4'd9, rv); chk("R3 disabled drops byte", rv & 32'hFFFF_FF00, STAT_BASE);
    wr(4'd2, 32'h0001_0008);
    chk("R3 ready when enabled", {31'h0, rx_ready}, 32'h1);

    // R4 fill beyond capacity
    for (int i = 0; i < 20; i++) push_byte(8'((i * 37 + 11) & 8'hFF));
    chk("R4 count capped", q.size(), 32'd16);
    chk("R4 ready low when full", {31'h0, rx_ready}, 32'h0);
    rd(4'd13, rv); chk("R9 raw bit3", rv, 32'h8);
    wr(4'd12, 32'h8);
    rd(4'd13, rv); chk("R9 ack cannot clear bit3", rv, 32'h8);
    rd(4'd9, rv); chk("R6 peek", rv, stat_exp());
    rd(4'd9, rv); chk("R6 peek again same", rv, stat_exp());
    while (q.size() != 0) begin
      rd(4'd8, rv); chk("R5 R6 pop order", rv, stat_exp());
      void'(q.pop_front());
    end
    rd(4'd13, rv); chk("R9 bit3 clears when empty", rv, 32'h0);

    // R7 pop on empty
    rd(4'd8, rv); chk("R7 empty pop", rv & 32'hFFFF_FF00, STAT_BASE);
    push_byte(8'h3C);
    rd(4'd9, rv); chk("R7 no underflow", rv, stat_exp());
    rd(4'd8, rv); void'(q.pop_front());

    // R8 wrapped pointers, simultaneous push and pop
    for (int i = 0; i < 10; i++) push_byte(8'(8'hA0 + i));
    for (int i = 0; i < 4; i++) begin
      logic [31:0] e;
      e = stat_exp();
      rx_data = 8'(8'h50 + i); rx_valid = 1'b1;
      bus_addr = 4'd8; bus_rd = 1'b1;
      @(negedge clk);
      rx_valid = 1'b0; bus_rd = 1'b0;
      chk("R8 pop during push", bus_rdata, e);
      void'(q.pop_front());
      q.push_back(8'(8'h50 + i));
    end
    chk("R8 count held", q.size(), 32'd10);
    while (q.size() != 0) begin
      rd(4'd8, rv); chk("R8 R4 order after wrap", rv, stat_exp());
      void'(q.pop_front());
    end

    // R11 mask sweep with raw = 0xB
    push_byte(8'h77);
    wr(4'd7, 32'h0);
    for (int m = 0; m < 16; m++) begin
      wr(4'd11, 32'hFFFF_FFF0 | m);
      rd(4'd14, rv); chk("R11 masked", rv, 32'hB & m);
      chk("R11 irq", {31'h0, irq}, {31'h0, |(4'hB & m[3:0])});
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule